// File: doc/BRIEF.md
# Master Bit Clock and Frame Sync Generator

This block runs a serial audio or telephony port as clock master. It divides a reference clock down to a 50% duty bit clock and counts bit clocks to produce a frame sync. Two single-cycle strobes mark each rising and each falling bit clock edge. A shift register running on the reference clock uses them to launch transmit bits on the rising edge and sample receive bits on the falling edge.

The sync pulse covers one whole serial word, not just one bit. It goes high on the same rising bit clock edge that launches the first bit of a frame. It drops once the number of bit clocks set by the word length has passed. When self-test loopback and master mode are both on, the generator keeps the bit clock running but will not begin a frame until the transmit FIFO reports that it holds data. With master mode off, the counters are cleared and both outputs stay low, so the port can take its clocks from outside.

All inputs are plain control and status levels. They are sampled on every reference clock edge, and there is no handshake. No data passes through the block, so it has no valid/ready stream port and no back-pressure.

Top module: `bfs_gen_top`

## Requirements
- R1: While `master_en` is low (sampled at a reference edge), `sclk`, `sync`, `sclk_rise` and `sclk_fall` are low after that edge and all counts are cleared. After `master_en` goes high, `sclk` first rises `div_val`+1 reference cycles later.
- R2: While enabled, `sclk` stays high for exactly `div_val`+1 reference cycles and low for exactly `div_val`+1 reference cycles, so its period is 2×(`div_val`+1).
- R3: `sclk_rise` is a one-cycle pulse in the first reference cycle in which `sclk` is high. `sclk_fall` is a one-cycle pulse in the first reference cycle in which `sclk` is low after being high.
- R4: Successive rising edges of `sync` are `frame_len`+1 bit clocks apart, counted in `sclk_rise` pulses.
- R5: While enabled, `sync` changes only in a cycle that carries `sclk_rise`. The first rising bit clock after enable starts a frame, with `sync` high.
- R6: When `word_len` < `frame_len`, `sync` stays high for exactly `word_len`+1 bit clocks of each frame. When `word_len` ≥ `frame_len`, `sync` stays high continuously once the first frame has started.
- R7: With `loop_en` and `master_en` both high, no frame starts while `tx_not_empty` is low: `sync` stays low but `sclk` keeps toggling. The first rising bit clock that sees `tx_not_empty` high starts a frame.
- R8: With `loop_en` low, `tx_not_empty` has no effect, and frames start back to back whatever its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master mode enable; low clears and silences the generator |
| loop_en | input | 1 | Self-test loopback enable; gates frame start on FIFO status |
| tx_not_empty | input | 1 | Transmit FIFO holds at least one word |
| div_val | input | 8 | Half-period of `sclk` in reference cycles, minus one |
| frame_len | input | 8 | Bits per frame minus one (1 to 256 bits) |
| word_len | input | 5 | Bits per serial word minus one (1 to 32 bits) |
| sclk | output | 1 | Generated bit clock |
| sync | output | 1 | Frame sync, one word wide |
| sclk_rise | output | 1 | Strobe in the first cycle of `sclk` high |
| sclk_fall | output | 1 | Strobe in the first cycle of `sclk` low |

## Verification
Assertions check on every cycle that each strobe matches a real transition of the bit clock, that the outputs are silenced whenever master mode is off, and that `sync` changes only on a rising-edge strobe. They also check that, under loopback, a frame never begins while the FIFO status is low. The exact half-period length, frame spacing and sync width depend on the programmed fields over many cycles. Only the bench's reference model and its measured scenarios show these, including the case where the word is longer than the frame and the release of a held frame.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int DIV_W = 8;
  localparam int FRM_W = 8;
  localparam int WRD_W = 5;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } frame_state_t;
endpackage

// File: rtl/bfs_clk_div.sv
module bfs_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             sclk,
  output logic             rise,
  output logic             fall,
  output logic             bit_step
);
  logic [DIV_W-1:0] hcnt;
  logic             half_done;

  assign half_done = (hcnt == div_val);
  // A rising edge of sclk is due at the next reference edge.
  assign bit_step  = en && half_done && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      sclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (!en) begin
      hcnt <= '0;
      sclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (half_done) begin
        hcnt <= '0;
        sclk <= ~sclk;
        rise <= ~sclk;
        fall <= sclk;
      end else begin
        hcnt <= hcnt + {{(DIV_W-1){1'b0}}, 1'b1};
      end
    end
  end

  a_r3_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (sclk && !$past(sclk)));
  a_r3_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!sclk && $past(sclk)));
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !rise && !fall));
  a_r2_edge_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(sclk)) |-> (rise || fall));
endmodule

// File: rtl/bfs_frame_ctr.sv
module bfs_frame_ctr
  import bfs_pkg::*;
#(
  parameter int FRM_W = 8,
  parameter int WRD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic             loop_en,
  input  logic             tx_not_empty,
  input  logic [FRM_W-1:0] frame_len,
  input  logic [WRD_W-1:0] word_len,
  output logic             sync
);
  localparam int CW = FRM_W + 1;

  frame_state_t     st;
  logic [FRM_W-1:0] bit_idx;
  logic [CW-1:0]    next_idx;
  logic [CW-1:0]    word_ext;
  logic             at_boundary;
  logic             may_start;

  assign next_idx    = {1'b0, bit_idx} + {{FRM_W{1'b0}}, 1'b1};
  assign word_ext    = {{(CW-WRD_W){1'b0}}, word_len};
  assign at_boundary = (st == FR_IDLE) || (bit_idx == frame_len);
  assign may_start   = !loop_en || tx_not_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FR_IDLE;
      bit_idx <= '0;
      sync    <= 1'b0;
    end else if (!en) begin
      st      <= FR_IDLE;
      bit_idx <= '0;
      sync    <= 1'b0;
    end else if (step) begin
      if (at_boundary) begin
        bit_idx <= '0;
        if (may_start) begin
          st   <= FR_RUN;
          sync <= 1'b1;
        end else begin
          st   <= FR_IDLE;
          sync <= 1'b0;
        end
      end else begin
        bit_idx <= next_idx[FRM_W-1:0];
        sync    <= (next_idx <= word_ext);
      end
    end
  end

  a_r5_sync_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(sync)) |-> $past(step));
  a_r7_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync) && $past(en) && $past(loop_en)) |-> $past(tx_not_empty));
  a_r1_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sync);
endmodule

// File: rtl/bfs_gen_top.sv
module bfs_gen_top
  import bfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             loop_en,
  input  logic             tx_not_empty,
  input  logic [DIV_W-1:0] div_val,
  input  logic [FRM_W-1:0] frame_len,
  input  logic [WRD_W-1:0] word_len,
  output logic             sclk,
  output logic             sync,
  output logic             sclk_rise,
  output logic             sclk_fall
);
  logic bit_step;

  bfs_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (master_en),
    .div_val  (div_val),
    .sclk     (sclk),
    .rise     (sclk_rise),
    .fall     (sclk_fall),
    .bit_step (bit_step)
  );

  bfs_frame_ctr #(.FRM_W(FRM_W), .WRD_W(WRD_W)) u_frm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (master_en),
    .step         (bit_step),
    .loop_en      (loop_en),
    .tx_not_empty (tx_not_empty),
    .frame_len    (frame_len),
    .word_len     (word_len),
    .sync         (sync)
  );

  a_r5_sync_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> sclk_rise);
endmodule

// File: tb/sim_bfs_gen_top.sv
module sim_bfs_gen_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0, loop_en = 1'b0, tx_not_empty = 1'b0;
  logic [7:0] div_val = 8'd0, frame_len = 8'd7;
  logic [4:0] word_len = 5'd2;
  logic sclk, sync, sclk_rise, sclk_fall;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_bit = 0;
  bit m_sclk = 0, m_rise = 0, m_fall = 0, m_sync = 0, m_frm = 0;

  // measurement state
  int since = 0, run = 0, per_cnt = 0;
  int meas_frame = -1, meas_width = -1, meas_period = -1, sync_rises = 0;
  bit ps = 0;

  always #2 clk = ~clk;

  bfs_gen_top u0 (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .loop_en(loop_en),
    .tx_not_empty(tx_not_empty), .div_val(div_val), .frame_len(frame_len),
    .word_len(word_len), .sclk(sclk), .sync(sync), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || !master_en) begin
      m_cnt = 0; m_sclk = 0; m_rise = 0; m_fall = 0;
      m_frm = 0; m_bit = 0; m_sync = 0;
    end else begin
      m_rise = 0; m_fall = 0;
      if (m_cnt == int'(div_val)) begin
        m_cnt = 0;
        m_sclk = !m_sclk;
        if (m_sclk) begin
          m_rise = 1;
          if (!m_frm || m_bit == int'(frame_len)) begin
            m_bit = 0;
            if (!loop_en || tx_not_empty) begin m_frm = 1; m_sync = 1; end
            else begin m_frm = 0; m_sync = 0; end
          end else begin
            m_bit = m_bit + 1;
            m_sync = (m_bit <= int'(word_len));
          end
        end else m_fall = 1;
      end else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check(sclk == m_sclk, "R2 sclk", sclk, m_sclk);
      check(sclk_rise == m_rise, "R3 sclk_rise", sclk_rise, m_rise);
      check(sclk_fall == m_fall, "R3 sclk_fall", sclk_fall, m_fall);
      check(sync == m_sync, "R5 sync", sync, m_sync);
      per_cnt++;
      if (sclk_rise) begin
        meas_period = per_cnt; per_cnt = 0;
        if (sync && !ps) begin
          meas_frame = since; since = 1; run = 1; sync_rises++;
        end else begin
          since++;
          if (sync) run++;
        end
        if (!sync && ps) meas_width = run;
        ps = sync;
      end
      if (cycles > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic clear_meas();
    since = 0; run = 0; per_cnt = 0; ps = 0; sync_rises = 0;
    meas_frame = -1; meas_width = -1; meas_period = -1;
  endtask

  task automatic configure(input int d, input int f, input int w, input bit lp, input bit tx);
    @(negedge clk);
    master_en = 1'b0;
    repeat (3) @(negedge clk);
    div_val = d[7:0]; frame_len = f[7:0]; word_len = w[4:0];
    loop_en = lp; tx_not_empty = tx;
    clear_meas();
    master_en = 1'b1;
  endtask

  task automatic measure(input int d, input int f, input int w);
    configure(d, f, w, 1'b0, 1'b0);
    repeat (2 * (d + 1) * (f + 1) * 3 + 20) @(negedge clk);
    check(meas_period == 2 * (d + 1), "R2 period", meas_period, 2 * (d + 1));
    check(meas_frame == f + 1, "R4 frame", meas_frame, f + 1);
    check(meas_width == w + 1, "R6 width", meas_width, w + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sclk == 0 && sync == 0 && sclk_rise == 0 && sclk_fall == 0, "R1 reset", sync, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(sclk == 0 && sync == 0, "R1 master off", sclk, 0);

    // first rise after enable: div=3 -> sclk high after 4 edges
    configure(3, 7, 2, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(sclk == 0, "R1 before first rise", sclk, 0);
    @(negedge clk);
    check(sclk_rise == 1 && sclk == 1, "R1 first rise", sclk_rise, 1);
    check(sync == 1, "R5 first frame sync", sync, 1);

    measure(0, 7, 2);
    measure(3, 15, 7);
    measure(1, 31, 15);
    measure(2, 4, 0);

    // R8: no loop, fifo status low -> frames still run
    configure(0, 7, 2, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    check(sync_rises >= 5, "R8 ignored without loop", sync_rises, 5);

    // R7: loop+master hold
    configure(1, 7, 2, 1'b1, 1'b0);
    repeat (200) @(negedge clk);
    check(sync_rises == 0, "R7 held", sync_rises, 0);
    check(meas_period == 4, "R7 sclk keeps running", meas_period, 4);
    tx_not_empty = 1'b1;
    repeat (40) @(negedge clk);
    check(sync_rises >= 1, "R7 released", sync_rises, 1);

    // R6: word longer than frame -> continuous
    configure(0, 3, 7, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    begin
      int lows = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (!sync) lows++;
      end
      check(lows == 0, "R6 continuous", lows, 0);
    end

    configure(0, 7, 2, 1'b0, 1'b0);
    @(negedge clk);
    master_en = 1'b0;
    @(negedge clk);
    check(sclk == 0 && sync == 0 && sclk_rise == 0, "R1 disable clears", sclk, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule